// File: doc/BRIEF.md
# NAND Read-Data Blank Page Detector

This block watches the bytes a NAND flash read command returns and gathers the statistics software needs to decide whether a page is erased or bad. Across the whole command it counts how many data bits were one and how many were zero. Each count is compared against a shared threshold. One flag shows that almost no ones were seen, and the other shows that almost no zeros were seen. Separately, the byte stream is cut into ECC data blocks by an end-of-block strobe. Each block is classified as all-0x00, all-0xFF or neither, and the result goes into a packed two-bit code per block.

Data enters on a valid/ready byte stream. The block never applies back-pressure: `in_ready` is held high, so a byte is accepted on every cycle in which `in_valid` is high. A one-cycle `cmd_start` pulse opens a new read command. Control inputs are plain pins. A small register captures the count-enable bit and the threshold on `cfg_we`.

Top module: `nand_blank_detect`

## Requirements
- R1: `in_ready` is 1 in every cycle out of reset, and a byte is accepted in every cycle where `in_valid` is 1.
- R2: When counting is enabled, each accepted byte adds its number of set bits to `ones_cnt` and 8 minus that number to `zeros_cnt`. The new totals are visible after the clock edge that accepts the byte.
- R3: The count-enable bit resets to 1. A `cfg_we` pulse loads `cfg_count_en` and `cfg_threshold`, and the new values apply to bytes from the next cycle onward. While the enable bit is 0, both counters hold their values.
- R4: `cmd_start` clears both counters. A byte accepted in the same cycle is counted as the first byte of the new command.
- R5: Each counter saturates at its all-ones value instead of wrapping.
- R6: `ones_low` is 1 exactly when `ones_cnt` is less than or equal to the 18-bit threshold (reset value 0). It follows the live count combinationally.
- R7: `zeros_low` is 1 exactly when `zeros_cnt` is less than or equal to the same threshold, and it follows the live count combinationally.
- R8: Block i's code sits in `pat_id[2i+1:2i]`. Code 0 means every byte of the block was 0x00. Code 1 means every byte was 0xFF. Code 2 means a mixed block or a block with no bytes. Code 3 is never produced. The code is written on the clock edge that sees `blk_end`, and a byte accepted in that same cycle belongs to the ending block. Pattern tracking runs whether or not counting is enabled.
- R9: Only the first 16 blocks of a command are recorded, and later `blk_end` pulses change nothing. `cmd_start` clears `pat_id` to 0 and restarts at block 0. A `blk_end` in the same cycle as `cmd_start` is ignored, and the byte in that cycle starts block 0.
- R10: After reset, both counters and `pat_id` are 0, and both flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the enable bit and threshold |
| cfg_count_en | input | 1 | New value of the count-enable bit |
| cfg_threshold | input | 18 | New threshold value |
| cmd_start | input | 1 | Start of a new read command |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Always 1; the block does not stall |
| in_data | input | 8 | Read data byte |
| blk_end | input | 1 | Current ECC block ends with this cycle |
| ones_cnt | output | 32 | Set bits seen in the current command |
| zeros_cnt | output | 32 | Clear bits seen in the current command |
| ones_low | output | 1 | `ones_cnt` is less than or equal to the threshold |
| zeros_low | output | 1 | `zeros_cnt` is less than or equal to the threshold |
| pat_id | output | 32 | Two-bit pattern code per ECC block |

## Verification
A corrupted counter shows on `ones_cnt` or `zeros_cnt` one cycle after the edge that took the bad step. The flags expose it in the same cycle, because they compare the live value. A fault in the per-block trackers (the all-zero, all-0xFF and seen bits) stays hidden until the next `blk_end`. One cycle after that edge it appears as a wrong two-bit code in the slot of the ending block. A wrong block index writes the right code into a neighbouring slot. This is caught the cycle after the write, because the whole `pat_id` vector is compared against a reference model every clock.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
  localparam int DEF_DATA_W   = 8;
  localparam int DEF_COUNT_W  = 32;
  localparam int DEF_THRESH_W = 18;
  localparam int DEF_MAX_BLK  = 16;

  typedef enum logic [1:0] {
    PAT_ZERO  = 2'd0,
    PAT_ONES  = 2'd1,
    PAT_MIXED = 2'd2
  } pat_code_e;
endpackage

// File: rtl/nbd_popcount.sv
module nbd_popcount #(
  parameter int DATA_W = 8,
  localparam int PC_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data,
  output logic [PC_W-1:0]   ones,
  output logic [PC_W-1:0]   zeros
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + PC_W'(data[i]);
    end
    zeros = PC_W'(DATA_W) - ones;
  end
endmodule

// File: rtl/nbd_sat_counter.sv
module nbd_sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);
  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W-1:0] cnt_d;

  always_comb begin
    base  = clr ? '0 : cnt;
    sum   = {1'b0, base} + (W+1)'(inc);
    cnt_d = base;
    if (inc_en) begin
      cnt_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3: without a step and without a clear the count holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !clr) |=> $stable(cnt));
  // R5: without a clear the count never goes down (no wrap)
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));
  // R4: a clear with no byte leaves zero
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc_en) |=> (cnt == '0));
endmodule

// File: rtl/nbd_pattern_track.sv
module nbd_pattern_track import nbd_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int MAX_BLK = 16,
  localparam int IDX_W  = $clog2(MAX_BLK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_start,
  input  logic                 byte_acc,
  input  logic [DATA_W-1:0]    byte_data,
  input  logic                 blk_end,
  output logic [2*MAX_BLK-1:0] pat_vec
);
  logic             all0_q, allf_q, seen_q;
  logic             all0_b, allf_b, seen_b;
  logic             all0_n, allf_n, seen_n;
  logic [IDX_W-1:0] idx_q;
  pat_code_e        code;

  always_comb begin
    all0_b = cmd_start ? 1'b1 : all0_q;
    allf_b = cmd_start ? 1'b1 : allf_q;
    seen_b = cmd_start ? 1'b0 : seen_q;
    all0_n = all0_b & (!byte_acc || byte_data == '0);
    allf_n = allf_b & (!byte_acc || byte_data == {DATA_W{1'b1}});
    seen_n = seen_b | byte_acc;
    if (!seen_n)     code = PAT_MIXED;
    else if (all0_n) code = PAT_ZERO;
    else if (allf_n) code = PAT_ONES;
    else             code = PAT_MIXED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all0_q  <= 1'b1;
      allf_q  <= 1'b1;
      seen_q  <= 1'b0;
      idx_q   <= '0;
      pat_vec <= '0;
    end else if (cmd_start) begin
      all0_q  <= all0_n;
      allf_q  <= allf_n;
      seen_q  <= seen_n;
      idx_q   <= '0;
      pat_vec <= '0;
    end else if (blk_end) begin
      all0_q <= 1'b1;
      allf_q <= 1'b1;
      seen_q <= 1'b0;
      if (idx_q < IDX_W'(MAX_BLK)) begin
        for (int i = 0; i < MAX_BLK; i++) begin
          if (idx_q == IDX_W'(i)) pat_vec[2*i +: 2] <= code;
        end
        idx_q <= idx_q + 1'b1;
      end
    end else begin
      all0_q <= all0_n;
      allf_q <= allf_n;
      seen_q <= seen_n;
    end
  end

  // R9: block index never passes the slot count
  p_idx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(MAX_BLK));
  // R9: a command start empties the code vector
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (pat_vec == '0));

  for (genvar g = 0; g < MAX_BLK; g++) begin : g_legal
    // R8: code 3 never appears in any slot
    p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pat_vec[2*g +: 2] != 2'b11);
  end
endmodule

// File: rtl/nand_blank_detect.sv
module nand_blank_detect import nbd_pkg::*; #(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int COUNT_W  = DEF_COUNT_W,
  parameter int THRESH_W = DEF_THRESH_W,
  parameter int MAX_BLK  = DEF_MAX_BLK
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_count_en,
  input  logic [THRESH_W-1:0]   cfg_threshold,
  input  logic                  cmd_start,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  input  logic                  blk_end,
  output logic [COUNT_W-1:0]    ones_cnt,
  output logic [COUNT_W-1:0]    zeros_cnt,
  output logic                  ones_low,
  output logic                  zeros_low,
  output logic [2*MAX_BLK-1:0]  pat_id
);
  localparam int PC_W  = $clog2(DATA_W + 1);
  localparam int CMP_W = (COUNT_W > THRESH_W) ? COUNT_W : THRESH_W;

  logic                count_en_q;
  logic [THRESH_W-1:0] thresh_q;
  logic                acc;
  logic [PC_W-1:0]     inc_amt [2];
  logic [COUNT_W-1:0]  cnt_q   [2];
  logic                low     [2];

  assign in_ready = 1'b1;
  assign acc      = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_en_q <= 1'b1;
      thresh_q   <= '0;
    end else if (cfg_we) begin
      count_en_q <= cfg_count_en;
      thresh_q   <= cfg_threshold;
    end
  end

  nbd_popcount #(.DATA_W(DATA_W)) u_pop (
    .data  (in_data),
    .ones  (inc_amt[0]),
    .zeros (inc_amt[1])
  );

  // index 0 counts ones, index 1 counts zeros
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    logic [CMP_W-1:0] cnt_ext, th_ext;

    nbd_sat_counter #(.W(COUNT_W), .INC_W(PC_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cmd_start),
      .inc_en (acc & count_en_q),
      .inc    (inc_amt[g]),
      .cnt    (cnt_q[g])
    );

    always_comb begin
      cnt_ext = CMP_W'(cnt_q[g]);
      th_ext  = CMP_W'(thresh_q);
      low[g]  = (cnt_ext <= th_ext);
    end
  end

  assign ones_cnt  = cnt_q[0];
  assign zeros_cnt = cnt_q[1];
  assign ones_low  = low[0];
  assign zeros_low = low[1];

  nbd_pattern_track #(.DATA_W(DATA_W), .MAX_BLK(MAX_BLK)) u_pat (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .byte_acc  (acc),
    .byte_data (in_data),
    .blk_end   (blk_end),
    .pat_vec   (pat_id)
  );

  // R1: every valid byte is taken
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready);
  // R6: a start with no counted byte leaves ones_low raised
  p_ones_low_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !(acc && count_en_q)) |=> ones_low);
  // R7: a start with no counted byte leaves zeros_low raised
  p_zeros_low_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !(acc && count_en_q)) |=> zeros_low);
  // R3: with counting off the ones count holds
  p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en_q && !cmd_start) |=> $stable(ones_cnt));
endmodule

// File: tb/nand_blank_detect_tb_top.sv
module nand_blank_detect_tb_top;
  localparam longint MAX32 = 64'hFFFF_FFFF;
  localparam longint MAX6  = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_count_en = 1'b0;
  logic [17:0] cfg_threshold = '0;
  logic        cmd_start = 1'b0, in_valid = 1'b0, blk_end = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, ones_low, zeros_low;
  logic [31:0] ones_cnt, zeros_cnt, pat_id;
  logic        s_ready, s_ones_low, s_zeros_low;
  logic [5:0]  s_ones, s_zeros;
  logic [31:0] s_pat;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nand_blank_detect dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_count_en(cfg_count_en),
    .cfg_threshold(cfg_threshold), .cmd_start(cmd_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .blk_end(blk_end),
    .ones_cnt(ones_cnt), .zeros_cnt(zeros_cnt), .ones_low(ones_low),
    .zeros_low(zeros_low), .pat_id(pat_id));

  // narrow-counter instance to reach saturation quickly
  nand_blank_detect #(.COUNT_W(6)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_count_en(cfg_count_en),
    .cfg_threshold(cfg_threshold), .cmd_start(cmd_start), .in_valid(in_valid),
    .in_ready(s_ready), .in_data(in_data), .blk_end(blk_end),
    .ones_cnt(s_ones), .zeros_cnt(s_zeros), .ones_low(s_ones_low),
    .zeros_low(s_zeros_low), .pat_id(s_pat));

  // reference model state
  longint m_ones = 0, m_zeros = 0, m_s_ones = 0, m_s_zeros = 0;
  bit     m_en = 1;
  longint m_th = 0;
  int     m_pat [16];
  int     m_idx = 0;
  bit     m_all0 = 1, m_allf = 1, m_seen = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint pat_vec_m();
    longint v = 0;
    for (int i = 0; i < 16; i++) v = v | (longint'(m_pat[i]) << (2*i));
    return v;
  endfunction

  task automatic compare_all();
    chk("R1 in_ready", longint'(in_ready), 1);
    chk("R2 R3 R4 ones_cnt", longint'(ones_cnt), m_ones);
    chk("R2 R3 R4 zeros_cnt", longint'(zeros_cnt), m_zeros);
    chk("R6 ones_low", longint'(ones_low), longint'(m_ones <= m_th));
    chk("R7 zeros_low", longint'(zeros_low), longint'(m_zeros <= m_th));
    chk("R8 R9 pat_id", longint'(pat_id), pat_vec_m());
    chk("R5 sat ones", longint'(s_ones), m_s_ones);
    chk("R5 sat zeros", longint'(s_zeros), m_s_zeros);
    chk("R6 sat ones_low", longint'(s_ones_low), longint'(m_s_ones <= m_th));
  endtask

  function automatic longint sat_add(longint a, longint b, longint mx);
    return (a + b > mx) ? mx : a + b;
  endfunction

  task automatic model_step(bit v, logic [7:0] d, bit cs, bit be, bit we,
                            bit en, logic [17:0] th);
    int p = $countones(d);
    if (cs) begin
      m_ones = 0; m_zeros = 0; m_s_ones = 0; m_s_zeros = 0;
    end
    if (v && m_en) begin
      m_ones    = sat_add(m_ones, p, MAX32);
      m_zeros   = sat_add(m_zeros, 8 - p, MAX32);
      m_s_ones  = sat_add(m_s_ones, p, MAX6);
      m_s_zeros = sat_add(m_s_zeros, 8 - p, MAX6);
    end
    if (we) begin
      m_en = en; m_th = longint'(th);
    end
    if (cs) begin
      for (int i = 0; i < 16; i++) m_pat[i] = 0;
      m_idx = 0; m_all0 = 1; m_allf = 1; m_seen = 0;
    end
    if (v) begin
      m_seen = 1;
      if (d != 8'h00) m_all0 = 0;
      if (d != 8'hFF) m_allf = 0;
    end
    if (be && !cs) begin
      int code = !m_seen ? 2 : m_all0 ? 0 : m_allf ? 1 : 2;
      if (m_idx < 16) begin
        m_pat[m_idx] = code;
        m_idx++;
      end
      m_all0 = 1; m_allf = 1; m_seen = 0;
    end
  endtask

  task automatic cyc(bit v, logic [7:0] d, bit cs, bit be,
                     bit we = 0, bit en = 0, logic [17:0] th = '0);
    @(negedge clk);
    compare_all();
    in_valid = v; in_data = d; cmd_start = cs; blk_end = be;
    cfg_we = we; cfg_count_en = en; cfg_threshold = th;
    @(posedge clk);
    model_step(v, d, cs, be, we, en, th);
  endtask

  task automatic idle(); cyc(0, 8'h00, 0, 0); endtask

  // send a block of n bytes; kind: 0=all 00, 1=all FF, 2=random,
  // 3=00 with one 01, 4=FF with one FE
  task automatic send_block(int n, int kind);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      case (kind)
        0: d = 8'h00;
        1: d = 8'hFF;
        2: d = 8'($urandom);
        3: d = (k == n/2) ? 8'h01 : 8'h00;
        default: d = (k == 1) ? 8'hFE : 8'hFF;
      endcase
      if ($urandom % 4 == 0) idle();
      cyc(1, d, 0, k == n-1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_pat[i] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset ones_cnt", longint'(ones_cnt), 0);
    chk("R10 reset zeros_cnt", longint'(zeros_cnt), 0);
    chk("R10 reset pat_id", longint'(pat_id), 0);
    chk("R10 reset ones_low", longint'(ones_low), 1);
    chk("R10 reset zeros_low", longint'(zeros_low), 1);
    rst_n = 1'b1;
    idle();

    // R2 R8: first command with four block kinds
    cyc(0, 8'h00, 1, 0);
    send_block(64, 0);
    send_block(64, 1);
    send_block(64, 2);
    send_block(64, 3);
    idle(); idle();

    // R6 R7: threshold write, near-all-ones page
    cyc(0, 8'h00, 0, 0, 1, 1, 18'd20);
    cyc(0, 8'h00, 1, 0);
    send_block(32, 4);
    send_block(32, 1);
    idle();

    // R3: counting off, patterns still tracked
    cyc(0, 8'h00, 0, 0, 1, 0, 18'd20);
    send_block(16, 2);
    send_block(16, 0);
    idle();
    cyc(0, 8'h00, 0, 0, 1, 1, 18'd300);
    send_block(16, 1);

    // R4 R9: start with a byte in the same cycle, start with blk_end
    cyc(1, 8'h0F, 1, 0);
    cyc(1, 8'h00, 0, 1);
    cyc(1, 8'hFF, 1, 1);
    cyc(1, 8'hFF, 0, 1);
    // R8 empty block, R9 overflow past 16 blocks
    cyc(0, 8'h00, 0, 1);
    for (int b = 0; b < 18; b++) send_block(2, b % 3);
    idle(); idle();

    // R5 long random command with large threshold
    cyc(0, 8'h00, 1, 0, 1, 1, 18'h3FFFF);
    for (int b = 0; b < 8; b++) send_block(40, b % 5);
    idle(); idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule